// File: doc/BRIEF.md
# Ethernet MAC Control and Interrupt Register Block

This block is the software-visible control and status register file of a simple Ethernet MAC. A host reaches it over a 32-bit bus that is addressed by word index (word index = byte offset / 4) and has separate read and write strobes. Read data is combinational and valid in the same cycle as the read strobe. Writes take effect at the next rising clock edge.

The block holds a mode register and a pair of interrupt registers: a latched source register and a mask. It also holds the frame length window, the transmit descriptor count and the 48-bit station address. The configuration fields drive the transmit and receive datapaths directly. The descriptor engines report their events as single-cycle pulses, which latch into the source register. A level interrupt line stays high while any latched event is also enabled in the mask.

The mode register resets to 0x0000A000. One of its bits is a soft reset that software sets and later clears. While that bit is set, the datapath is held in reset and every register keeps its contents.

Top module: `mac_csr_top`

## Requirements
- R1: After reset the registers hold these values. Mode (offset 0x00) reads 0x0000A000. Source (0x04) and mask (0x08) read 0. Frame length (0x18) reads 0x00400600. Transmit descriptor count (0x20) reads 64. Both address words (0x40, 0x44) read 0. irqOut is low.
- R2: Mode bit 0 drives cfgRxEn, bit 1 drives cfgTxEn and bit 5 drives cfgPromisc. The mode register stores bits 15:0, and bits 31:16 read as zero.
- R3: While mode bit 11 is one, dpReset is high. Setting or clearing that bit leaves every other register unchanged.
- R4: A one-cycle pulse sets a bit in the source register (0x04). evtTxDone sets bit 0, evtRxDone sets bit 2 and evtRxBusy sets bit 4.
- R5: Writing a one to a source bit position (0, 2 or 4) clears that bit. Writing a zero leaves it unchanged.
- R6: If an event pulse and a clearing write to the same source bit fall in the same cycle, the bit ends up set.
- R7: irqOut is high exactly while some source bit is one and the mask bit at the same position (0x08, bits 0/2/4) is also one.
- R8: The frame length register holds the minimum length in bits 31:16 (cfgMinLen) and the maximum length in bits 15:0 (cfgMaxLen).
- R9: A write to the transmit descriptor count stores the written value. A value above 128 is stored as 128.
- R10: Word 0x40 holds station address bytes 2..5, with byte 5 in bits 7:0. Word 0x44 holds bytes 0..1, with byte 1 in bits 7:0, and its bits 31:16 read as zero. cfgStationAddr carries byte 0 in bits 47:40 and byte 5 in bits 7:0.
- R11: Offsets outside the seven listed registers read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 5 | Word index of the register accessed |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, zero when no read or unmapped |
| evtTxDone | input | 1 | Pulse: frame transmitted |
| evtRxDone | input | 1 | Pulse: frame received |
| evtRxBusy | input | 1 | Pulse: frame dropped, no free buffer |
| irqOut | output | 1 | Level interrupt |
| dpReset | output | 1 | Datapath reset hold |
| cfgRxEn | output | 1 | Receive enable |
| cfgTxEn | output | 1 | Transmit enable |
| cfgPromisc | output | 1 | Accept all destination addresses |
| cfgMinLen | output | 16 | Minimum frame length |
| cfgMaxLen | output | 16 | Maximum frame length |
| cfgTxDescCnt | output | 8 | Number of transmit descriptors |
| cfgStationAddr | output | 48 | Station address, byte 0 most significant |

## Verification
An event pulse from a descriptor engine and a software clearing write to the source register can arrive in the same cycle. The bench provokes this by raising the receive-done pulse in the same cycle as a write of one to source bit 2. It then reads the source register and expects bit 2 still set. In the same cycle it clears a different bit, and expects that clear to take effect, so the result shows the collision is resolved per bit and not by dropping the whole write.

// File: rtl/mac_csr_pkg.sv
package mac_csr_pkg;

  localparam int DataW = 32;
  localparam int AddrW = 5;

  // Word indexes of the mapped registers (byte offset / 4)
  localparam int IdxMode   = 0;
  localparam int IdxSrc    = 1;
  localparam int IdxMask   = 2;
  localparam int IdxLen    = 6;
  localparam int IdxTxCnt  = 8;
  localparam int IdxAddrLo = 16;
  localparam int IdxAddrHi = 17;

  localparam int ModeW        = 16;
  localparam logic [ModeW-1:0] ModeRstVal = 16'hA000;
  localparam int BitRxEn      = 0;
  localparam int BitTxEn      = 1;
  localparam int BitPromisc   = 5;
  localparam int BitSoftRst   = 11;

  // Interrupt events: index 0 tx done, 1 rx done, 2 rx busy
  localparam int NumEvt = 3;
  localparam int EvtPos [NumEvt] = '{0, 2, 4};

  typedef enum logic [2:0] {
    SEL_NONE, SEL_MODE, SEL_SRC, SEL_MASK, SEL_LEN, SEL_TXCNT, SEL_ADDRLO, SEL_ADDRHI
  } regSelT;

  typedef struct packed {
    logic   wrMode;
    logic   wrSrc;
    logic   wrMask;
    logic   wrLen;
    logic   wrTxCnt;
    logic   wrAddrLo;
    logic   wrAddrHi;
    regSelT rdSel;
  } csrStrobeT;

endpackage

// File: rtl/mac_csr_decode.sv
module mac_csr_decode
  import mac_csr_pkg::*;
(
  input  logic [AddrW-1:0] busAddr,
  input  logic             busWr,
  input  logic             busRd,
  output csrStrobeT        strb
);

  regSelT hitSel;

  always_comb begin
    case (int'(busAddr))
      IdxMode:   hitSel = SEL_MODE;
      IdxSrc:    hitSel = SEL_SRC;
      IdxMask:   hitSel = SEL_MASK;
      IdxLen:    hitSel = SEL_LEN;
      IdxTxCnt:  hitSel = SEL_TXCNT;
      IdxAddrLo: hitSel = SEL_ADDRLO;
      IdxAddrHi: hitSel = SEL_ADDRHI;
      default:   hitSel = SEL_NONE;
    endcase
  end

  always_comb begin
    strb          = '0;
    strb.rdSel    = busRd ? hitSel : SEL_NONE;
    strb.wrMode   = busWr && (hitSel == SEL_MODE);
    strb.wrSrc    = busWr && (hitSel == SEL_SRC);
    strb.wrMask   = busWr && (hitSel == SEL_MASK);
    strb.wrLen    = busWr && (hitSel == SEL_LEN);
    strb.wrTxCnt  = busWr && (hitSel == SEL_TXCNT);
    strb.wrAddrLo = busWr && (hitSel == SEL_ADDRLO);
    strb.wrAddrHi = busWr && (hitSel == SEL_ADDRHI);
  end

endmodule

// File: rtl/mac_csr_int_bit.sv
module mac_csr_int_bit (
  input  logic clk,
  input  logic rstN,
  input  logic evtIn,
  input  logic clrIn,
  output logic srcOut
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      srcOut <= 1'b0;
    else if (evtIn) srcOut <= 1'b1;
    else if (clrIn) srcOut <= 1'b0;
  end

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rstN)
    evtIn |=> srcOut); // R4
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (clrIn && !evtIn) |=> !srcOut); // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (clrIn && evtIn) |=> srcOut); // R6
  AST_SRC_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!clrIn && !evtIn) |=> $stable(srcOut)); // R5

endmodule

// File: rtl/mac_csr_regfile.sv
module mac_csr_regfile
  import mac_csr_pkg::*;
#(
  parameter int TxCntMax  = 128,
  parameter int TxCntRst  = 64,
  parameter int LenMinRst = 64,
  parameter int LenMaxRst = 1536
) (
  input  logic              clk,
  input  logic              rstN,
  input  csrStrobeT         strb,
  input  logic [DataW-1:0]  wdata,
  input  logic [NumEvt-1:0] evtVec,
  output logic [DataW-1:0]  rdData,
  output logic              irq,
  output logic              dpHold,
  output logic              rxEn,
  output logic              txEn,
  output logic              promisc,
  output logic [15:0]       minLen,
  output logic [15:0]       maxLen,
  output logic [$clog2(TxCntMax+1)-1:0] txCnt,
  output logic [47:0]       stationAddr
);

  localparam int TxCntW = $clog2(TxCntMax + 1);
  localparam logic [DataW-1:0] TxCntLimit = DataW'(TxCntMax);

  logic [ModeW-1:0]  modeReg;
  logic [NumEvt-1:0] srcBits;
  logic [NumEvt-1:0] maskBits;
  logic [DataW-1:0]  lenReg;
  logic [TxCntW-1:0] txCntReg;
  logic [31:0]       addrLoReg;
  logic [15:0]       addrHiReg;
  logic [DataW-1:0]  srcWord;
  logic [DataW-1:0]  maskWord;

  // Latched interrupt sources, one cell per event
  for (genvar g = 0; g < NumEvt; g++) begin : gSrc
    mac_csr_int_bit uBit (
      .clk    (clk),
      .rstN   (rstN),
      .evtIn  (evtVec[g]),
      .clrIn  (strb.wrSrc && wdata[EvtPos[g]]),
      .srcOut (srcBits[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg   <= ModeRstVal;
      maskBits  <= '0;
      lenReg    <= {16'(LenMinRst), 16'(LenMaxRst)};
      txCntReg  <= TxCntW'(TxCntRst);
      addrLoReg <= '0;
      addrHiReg <= '0;
    end else begin
      if (strb.wrMode) modeReg <= wdata[ModeW-1:0];
      if (strb.wrMask) begin
        for (int i = 0; i < NumEvt; i++) maskBits[i] <= wdata[EvtPos[i]];
      end
      if (strb.wrLen) lenReg <= wdata;
      if (strb.wrTxCnt) begin
        if (wdata > TxCntLimit) txCntReg <= TxCntW'(TxCntMax);
        else                    txCntReg <= wdata[TxCntW-1:0];
      end
      if (strb.wrAddrLo) addrLoReg <= wdata[31:0];
      if (strb.wrAddrHi) addrHiReg <= wdata[15:0];
    end
  end

  always_comb begin
    srcWord  = '0;
    maskWord = '0;
    for (int i = 0; i < NumEvt; i++) begin
      srcWord[EvtPos[i]]  = srcBits[i];
      maskWord[EvtPos[i]] = maskBits[i];
    end
  end

  always_comb begin
    rdData = '0;
    case (strb.rdSel)
      SEL_MODE:   rdData[ModeW-1:0]  = modeReg;
      SEL_SRC:    rdData             = srcWord;
      SEL_MASK:   rdData             = maskWord;
      SEL_LEN:    rdData             = lenReg;
      SEL_TXCNT:  rdData[TxCntW-1:0] = txCntReg;
      SEL_ADDRLO: rdData[31:0]       = addrLoReg;
      SEL_ADDRHI: rdData[15:0]       = addrHiReg;
      default:    rdData             = '0;
    endcase
  end

  assign irq         = |(srcBits & maskBits);
  assign dpHold      = modeReg[BitSoftRst];
  assign rxEn        = modeReg[BitRxEn];
  assign txEn        = modeReg[BitTxEn];
  assign promisc     = modeReg[BitPromisc];
  assign minLen      = lenReg[31:16];
  assign maxLen      = lenReg[15:0];
  assign txCnt       = txCntReg;
  assign stationAddr = {addrHiReg, addrLoReg};

  AST_TXCNT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    txCntReg <= TxCntW'(TxCntMax)); // R9
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (maskBits != '0)); // R7
  AST_HOLD_KEEPS_LEN: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrMode && !strb.wrLen) |=> $stable(lenReg)); // R3
  AST_HOLD_KEEPS_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrMode && !strb.wrAddrLo) |=> $stable(addrLoReg)); // R3

endmodule

// File: rtl/mac_csr_top.sv
module mac_csr_top
  import mac_csr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [4:0]  busAddr,
  input  logic        busWr,
  input  logic        busRd,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  input  logic        evtTxDone,
  input  logic        evtRxDone,
  input  logic        evtRxBusy,
  output logic        irqOut,
  output logic        dpReset,
  output logic        cfgRxEn,
  output logic        cfgTxEn,
  output logic        cfgPromisc,
  output logic [15:0] cfgMinLen,
  output logic [15:0] cfgMaxLen,
  output logic [7:0]  cfgTxDescCnt,
  output logic [47:0] cfgStationAddr
);

  csrStrobeT strb;

  mac_csr_decode uDec (
    .busAddr (busAddr),
    .busWr   (busWr),
    .busRd   (busRd),
    .strb    (strb)
  );

  mac_csr_regfile #(
    .TxCntMax  (128),
    .TxCntRst  (64),
    .LenMinRst (64),
    .LenMaxRst (1536)
  ) uRegs (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wdata       (busWdata),
    .evtVec      ({evtRxBusy, evtRxDone, evtTxDone}),
    .rdData      (busRdata),
    .irq         (irqOut),
    .dpHold      (dpReset),
    .rxEn        (cfgRxEn),
    .txEn        (cfgTxEn),
    .promisc     (cfgPromisc),
    .minLen      (cfgMinLen),
    .maxLen      (cfgMaxLen),
    .txCnt       (cfgTxDescCnt),
    .stationAddr (cfgStationAddr)
  );

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && strb.rdSel == SEL_NONE) |-> (busRdata == 32'h0)); // R11
  AST_NO_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |-> (busRdata == 32'h0)); // R11

endmodule

// File: tb/sim_mac_csr_top.sv
module sim_mac_csr_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        evtTxDone = 1'b0;
  logic        evtRxDone = 1'b0;
  logic        evtRxBusy = 1'b0;
  logic        irqOut, dpReset, cfgRxEn, cfgTxEn, cfgPromisc;
  logic [15:0] cfgMinLen, cfgMaxLen;
  logic [7:0]  cfgTxDescCnt;
  logic [47:0] cfgStationAddr;

  int checkCount = 0;
  int failCount = 0;

  always #5 clk = ~clk;

  mac_csr_top u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .evtTxDone(evtTxDone),
    .evtRxDone(evtRxDone), .evtRxBusy(evtRxBusy), .irqOut(irqOut),
    .dpReset(dpReset), .cfgRxEn(cfgRxEn), .cfgTxEn(cfgTxEn),
    .cfgPromisc(cfgPromisc), .cfgMinLen(cfgMinLen), .cfgMaxLen(cfgMaxLen),
    .cfgTxDescCnt(cfgTxDescCnt), .cfgStationAddr(cfgStationAddr)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] offs, input logic [31:0] data);
    @(negedge clk);
    busAddr = offs[6:2]; busWdata = data; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] offs, output logic [31:0] data);
    @(negedge clk);
    busAddr = offs[6:2]; busRd = 1'b1;
    #1 data = busRdata;
    busRd = 1'b0;
  endtask

  task automatic readCheck(input string req, input logic [7:0] offs, input logic [31:0] exp);
    logic [31:0] d;
    busRead(offs, d);
    check(req, $sformatf("read 0x%02h", offs), 64'(d), 64'(exp));
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: evtTxDone = 1'b1;
      1: evtRxDone = 1'b1;
      default: evtRxBusy = 1'b1;
    endcase
    @(negedge clk);
    evtTxDone = 1'b0; evtRxDone = 1'b0; evtRxBusy = 1'b0;
  endtask

  task automatic tReset;
    readCheck("R1", 8'h00, 32'h0000A000);
    readCheck("R1", 8'h04, 32'h0);
    readCheck("R1", 8'h08, 32'h0);
    readCheck("R1", 8'h18, 32'h00400600);
    readCheck("R1", 8'h20, 32'd64);
    readCheck("R1", 8'h40, 32'h0);
    readCheck("R1", 8'h44, 32'h0);
    check("R1", "irqOut", 64'(irqOut), 64'd0);
  endtask

  task automatic tMode;
    busWrite(8'h00, 32'hFFFF0023);
    check("R2", "rx/tx/promisc on", 64'({cfgRxEn, cfgTxEn, cfgPromisc, dpReset}), 64'b1110);
    readCheck("R2", 8'h00, 32'h00000023);
    busWrite(8'h00, 32'h00000002);
    check("R2", "tx only", 64'({cfgRxEn, cfgTxEn, cfgPromisc}), 64'b010);
  endtask

  task automatic tSoftReset;
    busWrite(8'h18, 32'h00200100);
    busWrite(8'h40, 32'hA5A55A5A);
    busWrite(8'h00, 32'h00000803);
    check("R3", "dpReset set", 64'(dpReset), 64'd1);
    readCheck("R3", 8'h18, 32'h00200100);
    readCheck("R3", 8'h40, 32'hA5A55A5A);
    busWrite(8'h00, 32'h00000003);
    check("R3", "dpReset released", 64'(dpReset), 64'd0);
    readCheck("R3", 8'h18, 32'h00200100);
    check("R3", "enables kept", 64'({cfgRxEn, cfgTxEn}), 64'b11);
  endtask

  task automatic tEvents;
    pulse(0);
    readCheck("R4", 8'h04, 32'h01);
    pulse(1);
    readCheck("R4", 8'h04, 32'h05);
    pulse(2);
    readCheck("R4", 8'h04, 32'h15);
  endtask

  task automatic tW1c;
    busWrite(8'h04, 32'h00000004);
    readCheck("R5", 8'h04, 32'h11);
    busWrite(8'h04, 32'h00000000);
    readCheck("R5", 8'h04, 32'h11);
    busWrite(8'h04, 32'hFFFFFFFF);
    readCheck("R5", 8'h04, 32'h00);
  endtask

  task automatic tSetWins;
    pulse(0);
    @(negedge clk);
    busAddr = 5'd1; busWdata = 32'h00000005; busWr = 1'b1; evtRxDone = 1'b1;
    @(negedge clk);
    busWr = 1'b0; evtRxDone = 1'b0;
    readCheck("R6", 8'h04, 32'h04);
    busWrite(8'h04, 32'h04);
  endtask

  task automatic tIrq;
    busWrite(8'h08, 32'h0);
    pulse(2);
    check("R7", "masked busy", 64'(irqOut), 64'd0);
    busWrite(8'h08, 32'h10);
    check("R7", "unmasked busy", 64'(irqOut), 64'd1);
    readCheck("R7", 8'h08, 32'h10);
    busWrite(8'h04, 32'h10);
    check("R7", "cleared busy", 64'(irqOut), 64'd0);
    busWrite(8'h08, 32'h04);
    pulse(0);
    check("R7", "tx with rx mask", 64'(irqOut), 64'd0);
    pulse(1);
    check("R7", "rx with rx mask", 64'(irqOut), 64'd1);
    busWrite(8'h04, 32'h15);
    check("R7", "all cleared", 64'(irqOut), 64'd0);
  endtask

  task automatic tLen;
    busWrite(8'h18, 32'h05EE0040);
    check("R8", "min/max", 64'({cfgMinLen, cfgMaxLen}), 64'h05EE0040);
    readCheck("R8", 8'h18, 32'h05EE0040);
  endtask

  task automatic tTxCnt;
    busWrite(8'h20, 32'd128);
    readCheck("R9", 8'h20, 32'd128);
    busWrite(8'h20, 32'd7);
    check("R9", "cfg 7", 64'(cfgTxDescCnt), 64'd7);
    busWrite(8'h20, 32'd129);
    readCheck("R9", 8'h20, 32'd128);
    busWrite(8'h20, 32'h00000105);
    check("R9", "cfg sat", 64'(cfgTxDescCnt), 64'd128);
  endtask

  task automatic tAddr;
    busWrite(8'h40, 32'h33445566);
    busWrite(8'h44, 32'hFFFF1122);
    check("R10", "station", 64'(cfgStationAddr), 64'h112233445566);
    readCheck("R10", 8'h44, 32'h00001122);
    readCheck("R10", 8'h40, 32'h33445566);
  endtask

  task automatic tUnmapped;
    busWrite(8'h0C, 32'hFFFFFFFF);
    busWrite(8'h1C, 32'hFFFFFFFF);
    busWrite(8'h7C, 32'hFFFFFFFF);
    readCheck("R11", 8'h0C, 32'h0);
    readCheck("R11", 8'h7C, 32'h0);
    readCheck("R11", 8'h00, 32'h00000003);
    readCheck("R11", 8'h08, 32'h04);
    readCheck("R11", 8'h18, 32'h05EE0040);
    readCheck("R11", 8'h20, 32'd128);
    readCheck("R11", 8'h44, 32'h00001122);
    check("R11", "irq quiet", 64'(irqOut), 64'd0);
  endtask

  initial begin
    #2_000_000;
    checkCount++;
    failCount++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tMode();
    tSoftReset();
    tEvents();
    tW1c();
    tSetWins();
    tIrq();
    tLen();
    tTxCnt();
    tAddr();
    tUnmapped();
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule